// File: doc/BRIEF.md
# Serial Sampling Converter Output Interface

This block models the digital face of an 8-bit sampling converter that is read over a serial link. A host pulls chip select low to start a frame. At that moment the block latches the sample value and enters hold. It then shifts a 16-bit word out on a data line, one bit per serial clock falling edge, and drives an output enable that stands for the line's high-impedance control. The host captures each bit on the following rising edge. Analog behaviour is not modelled. The sample value comes from a stub input.

The block also tracks a simple power mode. The point at which chip select rises within a frame, counted in serial clock falling edges, decides the outcome. The host can leave the mode unchanged, send the block into shutdown, or abort the word while staying in normal mode. A frame that starts in shutdown wakes the block. Its result is marked unusable, and the block drops back into shutdown unless the frame runs far enough. Chip select and serial clock are asynchronous to the system clock. Both pass through two-flop synchronizers, and their edges are detected in the system clock domain.

Top module: `adc_serial_if`

## Requirements
- R1: After reset the output enable, hold indicator, shutdown indicator and serial data are low, and the valid flag is high.
- R2: A detected falling chip select latches sample_i, raises hold_o and sdata_oe_o. Changes to sample_i later in the frame do not alter the word shifted out.
- R3: The shifted word is {4'b0000, sample, 4'b0000}, 16 bits, most significant bit first. Bit 15 is driven from frame start, and bit 15-k is driven after the k-th serial clock falling edge. Data changes only after falling edges and holds steady across rising edges.
- R4: hold_o falls after the 13th rising serial clock edge of the frame, or earlier when chip select rises.
- R5: sdata_oe_o falls after the 16th falling serial clock edge, or earlier when chip select rises. Further serial clock edges in that frame have no effect.
- R6: sdata_o reads 0 whenever sdata_oe_o is low.
- R7: In normal mode, chip select rising after fewer than 2 falling edges leaves the mode unchanged.
- R8: In normal mode, chip select rising after 2 to 9 falling edges sets shutdown_o and aborts the frame.
- R9: In normal mode, chip select rising after 10 or more falling edges keeps normal mode and truncates the word.
- R10: A frame started in shutdown clears shutdown_o. If chip select rises before the 10th falling edge, shutdown_o is set again. Reaching the 10th falling edge moves the block to normal mode.
- R11: result_valid_o falls when a frame starts in shutdown. It rises at the 16th falling edge of a later frame that did not start in shutdown.
- R12: A chip select edge applied to the pin shows on sdata_oe_o on the third system clock rising edge after it is first sampled, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous, half period of at least 3 system clocks |
| sample_i | input | 8 | Sample value from the converter stub |
| sdata_o | output | 1 | Serial data, 0 when not enabled |
| sdata_oe_o | output | 1 | Data line drive enable (low means high impedance) |
| hold_o | output | 1 | High while in hold, low while tracking |
| shutdown_o | output | 1 | High while in shutdown mode |
| result_valid_o | output | 1 | Low while the current result follows a shutdown exit |

## Verification
The hardest state to reach from the ports is the wake frame. To get there, the host must first abort a normal frame inside the 2-to-9 edge window. It must then start another frame and end it on the correct side of the 10th edge, and only a later complete frame may restore the valid flag. Directed frames walk through each of these chains in turn. Random frames then stop chip select after 0 to 18 falling edges from any mode. A bench-side mode model predicts shutdown and valid after every chip select rise.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_SHDN   = 2'd1,
    MD_WAKE   = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/sif_sync_edge.sv
module sif_sync_edge #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sif_shifter.sv
module sif_shifter #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned TRAIL_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdata_o
);
  localparam int unsigned LEAD_W = FRAME_LEN - DATA_W - TRAIL_W;

  logic [FRAME_LEN-1:0] word_q;
  logic [FRAME_LEN-1:0] load_word;

  assign load_word = {{LEAD_W{1'b0}}, sample_i, {TRAIL_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (load_i) begin
      word_q <= load_word;
    end else if (shift_i) begin
      word_q <= {word_q[FRAME_LEN-2:0], 1'b0};
    end
  end

  assign sdata_o = oe_i & word_q[FRAME_LEN-1];
endmodule

// File: rtl/sif_frame_ctrl.sv
module sif_frame_ctrl
  import adc_sif_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned HOLD_RISE = 13,
  parameter int unsigned SHDN_LO   = 2,
  parameter int unsigned SHDN_HI   = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_fall_i,
  input  logic cs_rise_i,
  input  logic sclk_fall_i,
  input  logic sclk_rise_i,
  output logic load_o,
  output logic shift_o,
  output logic oe_o,
  output logic hold_o,
  output logic shutdown_o,
  output logic valid_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] HOLD_END  = CNT_W'(HOLD_RISE);
  localparam logic [CNT_W-1:0] SD_LO     = CNT_W'(SHDN_LO);
  localparam logic [CNT_W-1:0] SD_HI     = CNT_W'(SHDN_HI);

  logic             active_q;
  logic [CNT_W-1:0] fall_cnt_q, rise_cnt_q;
  logic [CNT_W-1:0] fall_nxt, rise_nxt;
  logic             hold_q, oe_q, valid_q, wake_q;
  pwr_mode_e        mode_q, mode_on_rise;

  assign fall_nxt = fall_cnt_q + 1'b1;
  assign rise_nxt = rise_cnt_q + 1'b1;

  // mode decision taken where chip select rises
  always_comb begin
    mode_on_rise = mode_q;
    unique case (mode_q)
      MD_NORMAL: if (fall_cnt_q >= SD_LO && fall_cnt_q < SD_HI) mode_on_rise = MD_SHDN;
      MD_WAKE:   mode_on_rise = (fall_cnt_q < SD_HI) ? MD_SHDN : MD_NORMAL;
      default:   mode_on_rise = mode_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      fall_cnt_q <= '0;
      rise_cnt_q <= '0;
      hold_q     <= 1'b0;
      oe_q       <= 1'b0;
      valid_q    <= 1'b1;
      wake_q     <= 1'b0;
      mode_q     <= MD_NORMAL;
    end else if (cs_fall_i) begin
      active_q   <= 1'b1;
      fall_cnt_q <= '0;
      rise_cnt_q <= '0;
      hold_q     <= 1'b1;
      oe_q       <= 1'b1;
      if (mode_q == MD_SHDN) begin
        mode_q  <= MD_WAKE;
        wake_q  <= 1'b1;
        valid_q <= 1'b0;
      end else begin
        wake_q  <= 1'b0;
      end
    end else if (cs_rise_i) begin
      active_q <= 1'b0;
      hold_q   <= 1'b0;
      oe_q     <= 1'b0;
      mode_q   <= mode_on_rise;
    end else if (active_q) begin
      if (sclk_fall_i) begin
        fall_cnt_q <= fall_nxt;
        if (mode_q == MD_WAKE && fall_nxt == SD_HI) mode_q <= MD_NORMAL;
        if (fall_nxt == LAST_FALL) begin
          active_q <= 1'b0;
          oe_q     <= 1'b0;
          hold_q   <= 1'b0;
          if (!wake_q) valid_q <= 1'b1;
        end
      end
      if (sclk_rise_i) begin
        rise_cnt_q <= rise_nxt;
        if (rise_nxt == HOLD_END) hold_q <= 1'b0;
      end
    end
  end

  assign load_o     = cs_fall_i;
  assign shift_o    = active_q & sclk_fall_i & ~cs_rise_i & ~cs_fall_i;
  assign oe_o       = oe_q;
  assign hold_o     = hold_q;
  assign shutdown_o = (mode_q == MD_SHDN);
  assign valid_o    = valid_q;
endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned TRAIL_W   = 4,
  parameter int unsigned HOLD_RISE = 13,
  parameter int unsigned SHDN_LO   = 2,
  parameter int unsigned SHDN_HI   = 10,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              hold_o,
  output logic              shutdown_o,
  output logic              result_valid_o
);
  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic load, shift, oe;

  sif_sync_edge #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) i_cs_sync (
    .clk_i, .rst_ni, .async_i(cs_ni), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  sif_sync_edge #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) i_sclk_sync (
    .clk_i, .rst_ni, .async_i(sclk_i), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  sif_frame_ctrl #(
    .FRAME_LEN(FRAME_LEN), .HOLD_RISE(HOLD_RISE), .SHDN_LO(SHDN_LO), .SHDN_HI(SHDN_HI)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .load_o(load), .shift_o(shift), .oe_o(oe),
    .hold_o(hold_o), .shutdown_o(shutdown_o), .valid_o(result_valid_o)
  );

  sif_shifter #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .TRAIL_W(TRAIL_W)) i_shift (
    .clk_i, .rst_ni, .load_i(load), .shift_i(shift), .oe_i(oe),
    .sample_i(sample_i), .sdata_o(sdata_o)
  );

  assign sdata_oe_o = oe;
endmodule

// File: rtl/adc_serial_if_chk.sv
module adc_serial_if_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic hold_o,
  input logic shutdown_o,
  input logic result_valid_o
);
  assert_quiet_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |-> !sdata_o);

  assert_hold_in_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> sdata_oe_o);

  assert_hold_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $rose(sdata_oe_o));

  assert_shdn_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> $fell(sdata_oe_o));

  assert_shdn_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> !sdata_oe_o);

  assert_wake_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shutdown_o) |-> ($rose(sdata_oe_o) && !result_valid_o));

  assert_valid_back_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(result_valid_o) |-> $fell(sdata_oe_o));

  assert_valid_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(result_valid_o) |-> $rose(sdata_oe_o));
endmodule

bind adc_serial_if adc_serial_if_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
  .hold_o(hold_o), .shutdown_o(shutdown_o), .result_valid_o(result_valid_o)
);

// File: tb/test_adc_serial_if.sv
module test_adc_serial_if;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       sclk_i = 1'b1;
  logic [7:0] sample_i = 8'h00;
  logic       sdata_o, sdata_oe_o, hold_o, shutdown_o, result_valid_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench mode model: 0 normal, 1 shutdown, 2 waking
  int exp_mode = 0;
  bit exp_valid = 1'b1;

  always #2 clk_i = ~clk_i;

  adc_serial_if i_adc_serial_if (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sample_i,
    .sdata_o, .sdata_oe_o, .hold_o, .shutdown_o, .result_valid_o
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic bit word_bit(logic [7:0] s, int k);
    logic [15:0] w;
    w = {4'b0000, s, 4'b0000};
    return w[15-k];
  endfunction

  function automatic int mode_after_rise(int m, int f);
    if (m == 0 && f >= 2 && f < 10) return 1;
    if (m == 2) return (f < 10) ? 1 : 0;
    return m;
  endfunction

  task automatic run_frame(logic [7:0] smp, int n_fall, bit alter);
    bit wake;
    int f;
    string tag;
    sample_i = smp;
    wait_clk(4);
    cs_ni = 1'b0;
    wait_clk(2);
    check("R12 oe before sync", int'(sdata_oe_o), 0);
    wait_clk(1);
    check("R12 oe after sync", int'(sdata_oe_o), 1);
    if (exp_mode == 1) begin
      exp_mode = 2; exp_valid = 1'b0; wake = 1'b1;
    end else begin
      wake = 1'b0;
    end
    check("R2 hold at start", int'(hold_o), 1);
    check("R10 shutdown at start", int'(shutdown_o), 0);
    check("R11 valid at start", int'(result_valid_o), int'(exp_valid));
    if (alter) sample_i = ~smp;
    check("R3 first bit", int'(sdata_o), int'(word_bit(smp, 0)));
    for (int k = 1; k <= n_fall; k++) begin
      sclk_i = 1'b0;
      wait_clk(4);
      if (k == 10 && exp_mode == 2) exp_mode = 0;
      if (k == 16 && !wake) exp_valid = 1'b1;
      check("R5 oe after fall", int'(sdata_oe_o), (k < 16) ? 1 : 0);
      if (k < 16) check("R3 bit after fall", int'(sdata_o), int'(word_bit(smp, k)));
      else        check("R6 line idle", int'(sdata_o), 0);
      sclk_i = 1'b1;
      wait_clk(4);
      check("R4 hold after rise", int'(hold_o), (k < 13) ? 1 : 0);
      if (k < 16) check("R3 bit stable on rise", int'(sdata_o), int'(word_bit(smp, k)));
    end
    cs_ni = 1'b1;
    wait_clk(5);
    f = (n_fall > 16) ? 16 : n_fall;
    if (exp_mode == 2)            tag = "R10 wake outcome";
    else if (f < 2)               tag = "R7 early rise";
    else if (f < 10)              tag = "R8 shutdown entry";
    else                          tag = "R9 late rise";
    exp_mode = mode_after_rise(exp_mode, f);
    check("R5 oe after cs rise", int'(sdata_oe_o), 0);
    check("R4 hold after cs rise", int'(hold_o), 0);
    check("R6 data after cs rise", int'(sdata_o), 0);
    check(tag, int'(shutdown_o), (exp_mode == 1) ? 1 : 0);
    check("R11 valid after frame", int'(result_valid_o), int'(exp_valid));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = $urandom(32'h5eed_2024);
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(4);
    check("R1 oe reset", int'(sdata_oe_o), 0);
    check("R1 hold reset", int'(hold_o), 0);
    check("R1 shutdown reset", int'(shutdown_o), 0);
    check("R1 valid reset", int'(result_valid_o), 1);
    check("R1 data reset", int'(sdata_o), 0);

    run_frame(8'hA5, 16, 1'b0);   // R3 full word
    run_frame(8'h3C, 1, 1'b0);    // R7
    run_frame(8'hFF, 0, 1'b0);    // R7
    run_frame(8'h81, 2, 1'b0);    // R8 lower bound
    run_frame(8'h5A, 16, 1'b0);   // R10 wake completes, R11 stays low
    run_frame(8'hC3, 16, 1'b0);   // R11 restored
    run_frame(8'h0F, 9, 1'b0);    // R8 upper bound
    run_frame(8'h77, 5, 1'b0);    // R10 falls back
    run_frame(8'h12, 12, 1'b0);   // R10 wakes, R9 truncation
    run_frame(8'hE7, 16, 1'b1);   // R2 sample change ignored, R11
    run_frame(8'h99, 10, 1'b0);   // R9 lower bound
    run_frame(8'h6B, 18, 1'b0);   // R5 extra edges ignored

    for (int i = 0; i < 120; i++) begin
      run_frame(8'($urandom), int'($urandom_range(0, 18)), 1'($urandom));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule